// File: doc/BRIEF.md
# Operand Address Generator

This block forms the memory addresses of one or two instruction operands. It supports seven addressing forms:

- address register plus a 16-bit displacement;
- program counter plus a 16-bit displacement;
- address register plus an index register plus an 8-bit displacement;
- program counter plus an index register plus an 8-bit displacement;
- a 16-bit absolute address;
- a 32-bit absolute address;
- register indirect with a step up after the access or a step down before it.

The caller gives one mode for the request and marks which operands take part: the source, the destination, or both. It also supplies the two-word instruction prefetch queue, the program counter, and the full data and address register files.

The program counter given to the block has already moved past the words held in the queue. PC-relative results are therefore corrected back to the address each extension word was fetched from. When both operands need an extension word, the older queue word belongs to the source and the newer one to the destination. For the stepping modes the block also returns the new value of the base address register and a write strobe. The register file write is left to the caller.

The block is a single pipeline stage. A request is accepted in any cycle and its results appear one clock later.

Top module: `ea_calc`

## Requirements
- R1: While `rst_n` is low and after its release, `res_valid`, `src_wr` and `dst_wr` are 0 until a request is accepted.
- R2: A request with `req_valid`=1 at a rising edge produces `res_valid`=1 for exactly the following cycle, with all results of that request. `res_valid` is 0 in a cycle that follows an edge without a request.
- R3: Mode 0 (address register plus displacement) gives An + sign-extended 16-bit extension word.
- R4: Mode 1 (PC plus displacement) with a single operand uses queue bits 15:0 and gives PC - 2 + the sign-extended word.
- R5: When both `use_src` and `use_dst` are 1, the source takes queue bits 31:16 with PC - 4 as its PC base, and the destination takes queue bits 15:0 with PC - 2.
- R6: Modes 2 and 3 decode the extension word as an index word. Bit 15 set selects an address register as the index, clear selects a data register. Bits 14:12 give the index register number. Bit 11 set uses the whole 32-bit index, clear uses its low 16 bits sign-extended. Bits 7:0 are a signed displacement. The sum is base + index + displacement, where the base is An in mode 2 and the corrected PC in mode 3.
- R7: Mode 4 gives the 16-bit extension word sign-extended to 32 bits.
- R8: Mode 5 gives the whole queue, bits 31:16 as the upper half, for every operand that is enabled.
- R9: Mode 6 (step after) gives An as the address and An + step as the new register value, with the operand's write strobe set.
- R10: Mode 7 (step before) gives An - step both as the address and as the new register value, with the write strobe set.
- R11: `op_size` 0 (byte) steps by 1, except on address register 7 where it steps by 2. `op_size` 1 (word) steps by 2. `op_size` 2 or 3 (long) steps by 4.
- R12: Modes 0 to 5 never set a write strobe. An operand whose enable is 0 returns address 0, write value 0 and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing form, 0 to 7 as in the requirements |
| use_src | input | 1 | Source operand takes part |
| use_dst | input | 1 | Destination operand takes part |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| src_reg | input | 3 | Source base address register number |
| dst_reg | input | 3 | Destination base address register number |
| prefetch_q | input | 32 | Queue; bits 31:16 are the older word |
| pc | input | 32 | Program counter, already past the queued words |
| data_file | input | 256 | Data registers, register i at bits 32*i+31:32*i |
| addr_file | input | 256 | Address registers, same packing |
| res_valid | output | 1 | Results valid |
| src_addr | output | 32 | Source effective address |
| dst_addr | output | 32 | Destination effective address |
| src_wr | output | 1 | Write strobe for the source base register |
| src_wr_val | output | 32 | New source base register value |
| dst_wr | output | 1 | Write strobe for the destination base register |
| dst_wr_val | output | 32 | New destination base register value |

## Verification
Every result of a request is registered once, so all results are due in the cycle right after the edge that accepted the request. The strobes are 0 again one cycle after that. The bench drives each request on a falling edge and takes the request away on the next falling edge. At that same falling edge it compares the outputs against its model, which was evaluated from the inputs it had driven. It then checks one idle cycle later that `res_valid` and both strobes have dropped. Directed cases cover the sign-extension edges, the index-word fields and the stack-pointer byte step. A long run with random values then spreads over every mode and both operand layouts.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EA_W = 32;

  typedef enum logic [2:0] {
    EA_DISP_AN  = 3'd0,
    EA_DISP_PC  = 3'd1,
    EA_IDX_AN   = 3'd2,
    EA_IDX_PC   = 3'd3,
    EA_ABS_S    = 3'd4,
    EA_ABS_L    = 3'd5,
    EA_POST_INC = 3'd6,
    EA_PRE_DEC  = 3'd7
  } ea_mode_e;

  function automatic logic [EA_W-1:0] sx16(input logic [15:0] w);
    return {{(EA_W-16){w[15]}}, w};
  endfunction

  function automatic logic [EA_W-1:0] sx8(input logic [7:0] b);
    return {{(EA_W-8){b[7]}}, b};
  endfunction

  // bytes moved by the stepping modes; the stack pointer stays word aligned
  function automatic logic [EA_W-1:0] step_bytes(input logic [1:0] sz, input logic is_sp);
    logic [EA_W-1:0] s;
    case (sz)
      2'd0:    s = is_sp ? EA_W'(2) : EA_W'(1);
      2'd1:    s = EA_W'(2);
      default: s = EA_W'(4);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ea_ext_pick.sv
module ea_ext_pick
  import ea_pkg::*;
#(
  parameter bit IS_DST = 1'b0
) (
  input  logic            both_ext,
  input  logic [31:0]     queue,
  input  logic [EA_W-1:0] pc,
  output logic [15:0]     ext_word,
  output logic [EA_W-1:0] pc_base
);
  generate
    if (IS_DST) begin : g_dst
      // destination always owns the newer word
      assign ext_word = queue[15:0];
      assign pc_base  = pc - EA_W'(2);
    end else begin : g_src
      // source owns the older word when both operands carry extensions
      assign ext_word = both_ext ? queue[31:16] : queue[15:0];
      assign pc_base  = pc - (both_ext ? EA_W'(4) : EA_W'(2));
    end
  endgenerate
endmodule

// File: rtl/ea_index.sv
module ea_index
  import ea_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int RIW  = $clog2(NREGS)
) (
  input  logic [15:0]           brief,
  input  logic [NREGS*EA_W-1:0] data_file,
  input  logic [NREGS*EA_W-1:0] addr_file,
  output logic [EA_W-1:0]       offset
);
  logic [RIW-1:0]  idx_num;
  logic [EA_W-1:0] idx_raw;
  logic [EA_W-1:0] idx_val;

  assign idx_num = brief[12 +: RIW];
  assign idx_raw = brief[15] ? addr_file[idx_num*EA_W +: EA_W]
                             : data_file[idx_num*EA_W +: EA_W];
  assign idx_val = brief[11] ? idx_raw : sx16(idx_raw[15:0]);
  assign offset  = idx_val + sx8(brief[7:0]);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int RIW  = $clog2(NREGS)
) (
  input  ea_mode_e              mode,
  input  logic                  enable,
  input  logic [1:0]            size,
  input  logic [RIW-1:0]        base_reg,
  input  logic [15:0]           ext_word,
  input  logic [31:0]           queue,
  input  logic [EA_W-1:0]       pc_base,
  input  logic [NREGS*EA_W-1:0] data_file,
  input  logic [NREGS*EA_W-1:0] addr_file,
  output logic [EA_W-1:0]       ea,
  output logic                  wr,
  output logic [EA_W-1:0]       wr_val
);
  logic [EA_W-1:0] base_an;
  logic [EA_W-1:0] step;
  logic [EA_W-1:0] idx_off;
  logic            is_step_mode;
  logic [EA_W-1:0] raw_ea;
  logic [EA_W-1:0] raw_upd;

  assign base_an      = addr_file[base_reg*EA_W +: EA_W];
  assign step         = step_bytes(size, base_reg == RIW'(NREGS-1));
  assign is_step_mode = (mode == EA_POST_INC) || (mode == EA_PRE_DEC);

  ea_index #(.NREGS(NREGS)) u_idx (
    .brief     (ext_word),
    .data_file (data_file),
    .addr_file (addr_file),
    .offset    (idx_off)
  );

  always_comb begin
    raw_upd = base_an;
    case (mode)
      EA_DISP_AN:  raw_ea = base_an + sx16(ext_word);
      EA_DISP_PC:  raw_ea = pc_base + sx16(ext_word);
      EA_IDX_AN:   raw_ea = base_an + idx_off;
      EA_IDX_PC:   raw_ea = pc_base + idx_off;
      EA_ABS_S:    raw_ea = sx16(ext_word);
      EA_ABS_L:    raw_ea = queue;
      EA_POST_INC: begin
        raw_ea  = base_an;
        raw_upd = base_an + step;
      end
      default: begin
        raw_ea  = base_an - step;
        raw_upd = raw_ea;
      end
    endcase
  end

  assign ea     = enable ? raw_ea : '0;
  assign wr     = enable && is_step_mode;
  assign wr_val = wr ? raw_upd : '0;
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int RIW  = $clog2(NREGS),
  localparam int FW   = NREGS * EA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      mode,
  input  logic            use_src,
  input  logic            use_dst,
  input  logic [1:0]      op_size,
  input  logic [RIW-1:0]  src_reg,
  input  logic [RIW-1:0]  dst_reg,
  input  logic [31:0]     prefetch_q,
  input  logic [EA_W-1:0] pc,
  input  logic [FW-1:0]   data_file,
  input  logic [FW-1:0]   addr_file,
  output logic            res_valid,
  output logic [EA_W-1:0] src_addr,
  output logic [EA_W-1:0] dst_addr,
  output logic            src_wr,
  output logic [EA_W-1:0] src_wr_val,
  output logic            dst_wr,
  output logic [EA_W-1:0] dst_wr_val
);
  localparam int NOPS = 2;

  logic            both_ext;
  logic [EA_W-1:0] ea_c   [NOPS];
  logic            wr_c   [NOPS];
  logic [EA_W-1:0] upd_c  [NOPS];
  logic [EA_W-1:0] ea_q   [NOPS];
  logic            wr_q   [NOPS];
  logic [EA_W-1:0] upd_q  [NOPS];

  assign both_ext = use_src && use_dst;

  for (genvar op = 0; op < NOPS; op++) begin : g_op
    logic [15:0]     ext_word;
    logic [EA_W-1:0] pc_base;

    ea_ext_pick #(.IS_DST(op == 1)) u_pick (
      .both_ext (both_ext),
      .queue    (prefetch_q),
      .pc       (pc),
      .ext_word (ext_word),
      .pc_base  (pc_base)
    );

    ea_unit #(.NREGS(NREGS)) u_unit (
      .mode      (ea_mode_e'(mode)),
      .enable    ((op == 1) ? use_dst : use_src),
      .size      (op_size),
      .base_reg  ((op == 1) ? dst_reg : src_reg),
      .ext_word  (ext_word),
      .queue     (prefetch_q),
      .pc_base   (pc_base),
      .data_file (data_file),
      .addr_file (addr_file),
      .ea        (ea_c[op]),
      .wr        (wr_c[op]),
      .wr_val    (upd_c[op])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ea_q[op]  <= '0;
        wr_q[op]  <= 1'b0;
        upd_q[op] <= '0;
      end else begin
        wr_q[op] <= req_valid && wr_c[op];
        if (req_valid) begin
          ea_q[op]  <= ea_c[op];
          upd_q[op] <= upd_c[op];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= req_valid;
  end

  assign src_addr   = ea_q[0];
  assign dst_addr   = ea_q[1];
  assign src_wr     = wr_q[0];
  assign dst_wr     = wr_q[1];
  assign src_wr_val = upd_q[0];
  assign dst_wr_val = upd_q[1];
endmodule

// File: rtl/ea_calc_chk.sv
module ea_calc_chk
  import ea_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int RIW  = $clog2(NREGS),
  localparam int FW   = NREGS * EA_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [2:0]      mode,
  input logic            use_src,
  input logic            use_dst,
  input logic [1:0]      op_size,
  input logic [RIW-1:0]  src_reg,
  input logic [RIW-1:0]  dst_reg,
  input logic [31:0]     prefetch_q,
  input logic [EA_W-1:0] pc,
  input logic [FW-1:0]   data_file,
  input logic [FW-1:0]   addr_file,
  input logic            res_valid,
  input logic [EA_W-1:0] src_addr,
  input logic [EA_W-1:0] dst_addr,
  input logic            src_wr,
  input logic [EA_W-1:0] src_wr_val,
  input logic            dst_wr,
  input logic [EA_W-1:0] dst_wr_val
);
  logic [EA_W-1:0] src_an;
  logic [EA_W-1:0] src_delta;
  assign src_an    = addr_file[src_reg*EA_W +: EA_W];
  assign src_delta = src_wr_val - src_addr;

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R2
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && !src_wr && !dst_wr);
  // R8
  abs_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 3'd5 && use_src |=> src_addr == $past(prefetch_q));
  // R9
  post_inc_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 3'd6 && use_src |=> src_wr && src_addr == $past(src_an));
  // R10
  pre_dec_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 3'd7 && use_src |=> src_wr && src_wr_val == src_addr);
  // R11
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_wr && $past(mode) == 3'd6 |-> $countones(src_delta) == 1 && src_delta <= EA_W'(4));
  // R12
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode < 3'd6 |=> !src_wr && !dst_wr);
endmodule

bind ea_calc ea_calc_chk #(.NREGS(NREGS)) u_chk (.*);

// File: tb/ea_calc_tb.sv
module ea_calc_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [2:0]   mode = '0;
  logic         use_src = 1'b0, use_dst = 1'b0;
  logic [1:0]   op_size = '0;
  logic [2:0]   src_reg = '0, dst_reg = '0;
  logic [31:0]  prefetch_q = '0, pc = '0;
  logic [255:0] data_file, addr_file;
  logic         res_valid, src_wr, dst_wr;
  logic [31:0]  src_addr, dst_addr, src_wr_val, dst_wr_val;

  logic [31:0] dr [8];
  logic [31:0] ar [8];
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      data_file[i*32 +: 32] = dr[i];
      addr_file[i*32 +: 32] = ar[i];
    end
  end

  ea_calc u_dut (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference for one operand
  task automatic model(input int op, output logic [31:0] ea, output logic wr, output logic [31:0] val);
    bit both = use_src && use_dst;
    bit en = (op == 0) ? use_src : use_dst;
    int r = (op == 0) ? src_reg : dst_reg;
    logic [15:0] w = (both && op == 0) ? prefetch_q[31:16] : prefetch_q[15:0];
    int pcb = int'(pc) - ((both && op == 0) ? 4 : 2);
    int an = int'(ar[r]);
    int stp = (op_size == 0) ? ((r == 7) ? 2 : 1) : (op_size == 1) ? 2 : 4;
    int disp = int'(signed'(w));
    int ix = w[15] ? int'(ar[w[14:12]]) : int'(dr[w[14:12]]);
    int xo;
    if (!w[11]) ix = int'(signed'(ix[15:0]));
    xo = ix + int'(signed'(w[7:0]));
    wr = 0; val = 0;
    case (mode)
      0: ea = 32'(an + disp);
      1: ea = 32'(pcb + disp);
      2: ea = 32'(an + xo);
      3: ea = 32'(pcb + xo);
      4: ea = 32'(disp);
      5: ea = prefetch_q;
      6: begin ea = 32'(an); wr = 1; val = 32'(an + stp); end
      default: begin ea = 32'(an - stp); wr = 1; val = ea; end
    endcase
    if (!en) begin ea = 0; wr = 0; val = 0; end
  endtask

  task automatic run(input string req, input logic [2:0] m, input bit us, input bit ud,
                     input logic [1:0] sz, input logic [2:0] sr, input logic [2:0] dg,
                     input logic [31:0] q, input logic [31:0] p);
    logic [31:0] e0, e1, v0, v1;
    logic w0, w1;
    mode = m; use_src = us; use_dst = ud; op_size = sz;
    src_reg = sr; dst_reg = dg; prefetch_q = q; pc = p; req_valid = 1;
    model(0, e0, w0, v0);
    model(1, e1, w1, v1);
    @(negedge clk);
    req_valid = 0;
    check({req, " R2"}, "res_valid", 32'(res_valid), 32'd1);
    check(req, "src_addr", src_addr, e0);
    check(req, "dst_addr", dst_addr, e1);
    check({req, " R12"}, "src_wr", 32'(src_wr), 32'(w0));
    check({req, " R12"}, "dst_wr", 32'(dst_wr), 32'(w1));
    check(req, "src_wr_val", src_wr_val, v0);
    check(req, "dst_wr_val", dst_wr_val, v1);
    @(negedge clk);
    check("R2 idle", "res_valid", 32'(res_valid), 32'd0);
    check("R2 idle", "wr", 32'(src_wr | dst_wr), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      dr[i] = 32'h1000_0000 * i + 32'h10 * i;
      ar[i] = 32'h0002_0000 + 32'h100 * i;
    end
    dr[3] = 32'h0001_FFF0;
    ar[5] = 32'h1234_8008;
    repeat (3) @(negedge clk);
    // R1
    check("R1", "res_valid", 32'(res_valid), 0);
    check("R1", "src_wr", 32'(src_wr), 0);
    check("R1", "dst_wr", 32'(dst_wr), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", "res_valid", 32'(res_valid), 0);
    // R3 negative displacement
    run("R3", 3'd0, 1, 0, 2'd1, 3'd2, 3'd0, 32'h0000_FFF0, 32'h100);
    // R4
    run("R4", 3'd1, 1, 0, 2'd1, 3'd0, 3'd0, 32'hAAAA_0010, 32'h4000);
    run("R4 dst", 3'd1, 0, 1, 2'd1, 3'd0, 3'd0, 32'hAAAA_8000, 32'h4000);
    // R5
    run("R5", 3'd1, 1, 1, 2'd1, 3'd1, 3'd4, 32'h0020_FFFE, 32'h8000);
    run("R5 disp", 3'd0, 1, 1, 2'd1, 3'd1, 3'd4, 32'hFFFC_0040, 32'h0);
    // R6: word index from D3 (negative low half), negative disp
    run("R6 dword", 3'd2, 1, 0, 2'd0, 3'd1, 3'd0, 32'h0000_30F0, 32'h0);
    // R6: long index from A5, via PC
    run("R6 along", 3'd3, 1, 0, 2'd0, 3'd0, 3'd0, 32'h0000_D87F, 32'h2000);
    run("R6 dual", 3'd2, 1, 1, 2'd0, 3'd6, 3'd7, 32'h8801_3880, 32'h0);
    // R7
    run("R7", 3'd4, 1, 0, 2'd0, 3'd0, 3'd0, 32'h0000_8000, 32'h0);
    run("R7 pos", 3'd4, 0, 1, 2'd0, 3'd0, 3'd0, 32'h0000_7FFE, 32'h0);
    // R8
    run("R8", 3'd5, 1, 1, 2'd2, 3'd0, 3'd0, 32'hDEAD_BEEF, 32'h0);
    // R9 / R11
    run("R9 R11 byte", 3'd6, 1, 0, 2'd0, 3'd3, 3'd0, 32'h0, 32'h0);
    run("R9 R11 word", 3'd6, 1, 1, 2'd1, 3'd3, 3'd4, 32'h0, 32'h0);
    run("R9 R11 sp byte", 3'd6, 0, 1, 2'd0, 3'd0, 3'd7, 32'h0, 32'h0);
    // R10 / R11
    run("R10 R11 sp byte", 3'd7, 1, 0, 2'd0, 3'd7, 3'd0, 32'h0, 32'h0);
    run("R10 R11 long", 3'd7, 1, 0, 2'd2, 3'd2, 3'd0, 32'h0, 32'h0);
    run("R10 R11 size3", 3'd7, 0, 1, 2'd3, 3'd0, 3'd1, 32'h0, 32'h0);
    // R12 disabled operands
    run("R12 none", 3'd6, 0, 0, 2'd1, 3'd1, 3'd1, 32'h0, 32'h0);
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 8; i++) begin
        dr[i] = $urandom;
        ar[i] = $urandom;
      end
      run("R3-R12 mix", 3'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
          3'($urandom), 3'($urandom), $urandom, $urandom);
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired R2");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule